// File: doc/BRIEF.md
# Data Cache Line State Controller

This block holds the coherence state of one data cache line (invalid, valid or modified) and decides how each access to that line is served. One request is taken at a time. It carries an access kind, a hit indication from the tag logic outside, and the write policy of that access: copyback or write-through. The block works out which memory transfers are needed and runs them one after another over a request/done handshake. When the last transfer completes, it emits the cache-side strobes and commits the new line state.

The memory transfers are a line fill, a single-word write to memory, and a line writeback. A miss on a dirty line always writes the line back before anything else. Write-through writes never allocate a line. Two push commands exist: one drops the line afterwards and the other keeps it. A hit reported for an invalid line is treated as a broken request. The block flags it and does nothing else.

Top module: `dcache_line_ctrl`

## Requirements
- R1: After reset the line state is invalid (code 0), `ready` is high, and `mem_req`, `cache_wr`, `cpu_supply` and `err_hit_inv` are low.
- R2: Invalid line, read miss (kind 0), either policy: one fill (mem_op 1), then one `cpu_supply` pulse, and the state becomes valid (code 1).
- R3: Invalid line, copyback write miss (kind 1, `req_copyback`=1): one fill, then one `cache_wr` pulse, and the state becomes modified (code 2).
- R4: Invalid line, write-through write miss: one word write to memory (mem_op 2), no cache strobe, and the state stays invalid.
- R5: Valid line: a read hit gives only a `cpu_supply` pulse and the state stays valid. A read miss gives a fill and a supply pulse and the state stays valid.
- R6: Valid line, write hit: copyback gives only a `cache_wr` pulse and the state becomes modified. Write-through gives a word write plus `cache_wr` and the state stays valid.
- R7: Valid line, write miss: copyback gives a fill plus `cache_wr` and the state becomes modified. Write-through gives only a word write and the state stays valid.
- R8: Invalidate (kind 2) makes no memory transfer and raises no strobe, and the state becomes invalid from any state, a modified line included. Kind codes 5 to 7 make no transfer and no strobe and leave the state unchanged.
- R9: A read or write with `req_hit`=1 while the line is invalid raises `err_hit_inv` for one cycle after acceptance. No transfer or strobe follows, the state stays invalid and `ready` stays high.
- R10: Push-and-drop (kind 3) and push-and-keep (kind 4) do nothing on an invalid line. On a valid line they make no transfer and end invalid or valid respectively. On a modified line they make one writeback (mem_op 3) and then end invalid or valid respectively.
- R11: Modified line: a read hit supplies data, and any write hit raises `cache_wr` and keeps the state modified (write-through also makes a word write). A read or write miss first makes a writeback and then the same transfers and strobes as on a valid line, ending valid for a read or a write-through write and modified for a copyback write.
- R12: `mem_req` stays high with a stable `mem_op` until `mem_done` is seen. `ready` is low from acceptance until commit. Strobes occur only in the single commit cycle after the last transfer completes, and the line state changes only at that commit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present; taken when `ready` is high |
| req_kind | input | 3 | 0 read, 1 write, 2 invalidate, 3 push-and-drop, 4 push-and-keep |
| req_hit | input | 1 | Tag match for this request |
| req_copyback | input | 1 | 1 copyback, 0 write-through |
| ready | output | 1 | Idle and able to take a request |
| line_state | output | 2 | 0 invalid, 1 valid, 2 modified |
| mem_req | output | 1 | Memory transfer request, held until done |
| mem_op | output | 2 | 1 line fill, 2 word write, 3 line writeback |
| mem_done | input | 1 | Completion pulse for the current transfer |
| cache_wr | output | 1 | Write the request data into the cache line |
| cpu_supply | output | 1 | Return line data to the processor |
| err_hit_inv | output | 1 | Hit reported on an invalid line |

## Verification
The bench starts from each of the three states and sends every kind code with every hit and policy combination. Each time it records the ordered list of memory transfers, the strobes and the final state. A design that dropped the writeback before a dirty miss would show a single fill where two transfers are expected. One that allocated on a write-through miss would end valid instead of invalid. One that confused the two push kinds would end in the wrong state, and one that wrote back on an invalidate would show a stray transfer. The bench holds off `mem_done` for a cycle to check that the request is held and that the state does not move before the final completion. The impossible-hit case is checked to raise the flag while leaving `ready` high and the line untouched.

// File: rtl/dcl_pkg.sv
package dcl_pkg;

    localparam int STATE_W   = 2;
    localparam int KIND_W    = 3;
    localparam int MOP_W     = 2;
    localparam int OPQ_DEPTH = 2;

    typedef enum logic [STATE_W-1:0] {
        LS_INV = 2'd0,
        LS_VAL = 2'd1,
        LS_MOD = 2'd2
    } line_state_e;

    typedef enum logic [KIND_W-1:0] {
        AK_READ      = 3'd0,
        AK_WRITE     = 3'd1,
        AK_INVAL     = 3'd2,
        AK_PUSH_DROP = 3'd3,
        AK_PUSH_KEEP = 3'd4
    } acc_kind_e;

    typedef enum logic [MOP_W-1:0] {
        MOP_NONE  = 2'd0,
        MOP_FILL  = 2'd1,
        MOP_WORD  = 2'd2,
        MOP_WBACK = 2'd3
    } mem_op_e;

    typedef struct packed {
        logic                         err;
        mem_op_e [OPQ_DEPTH-1:0]      ops;
        line_state_e                  nxt;
        logic                         wr_cache;
        logic                         supply;
    } plan_t;

endpackage

// File: rtl/dcl_decode.sv
module dcl_decode
    import dcl_pkg::*;
(
    input  line_state_e             state_i,
    input  logic [KIND_W-1:0]       kind_i,
    input  logic                    hit_i,
    input  logic                    copyback_i,
    output plan_t                   plan_o
);

    plan_t   p;
    mem_op_e first_op;
    logic    dirty_miss;

    always_comb begin
        p          = '0;
        p.nxt      = state_i;
        first_op   = MOP_NONE;
        dirty_miss = (state_i == LS_MOD) && !hit_i;

        case (kind_i)
            AK_READ: begin
                if (state_i == LS_INV && hit_i) begin
                    p.err = 1'b1;
                end else begin
                    p.supply = 1'b1;
                    if (!hit_i || state_i == LS_INV) begin
                        first_op = MOP_FILL;
                        p.nxt    = LS_VAL;
                    end
                end
            end
            AK_WRITE: begin
                if (state_i == LS_INV && hit_i) begin
                    p.err = 1'b1;
                end else if (hit_i) begin
                    p.wr_cache = 1'b1;
                    if (copyback_i) begin
                        p.nxt = LS_MOD;
                    end else begin
                        first_op = MOP_WORD;
                    end
                end else if (copyback_i) begin
                    first_op   = MOP_FILL;
                    p.wr_cache = 1'b1;
                    p.nxt      = LS_MOD;
                end else begin
                    first_op = MOP_WORD;
                    p.nxt    = (state_i == LS_INV) ? LS_INV : LS_VAL;
                end
            end
            AK_INVAL: begin
                p.nxt = LS_INV;
            end
            AK_PUSH_DROP: begin
                if (state_i == LS_MOD) first_op = MOP_WBACK;
                p.nxt = LS_INV;
            end
            AK_PUSH_KEEP: begin
                if (state_i == LS_MOD) begin
                    first_op = MOP_WBACK;
                    p.nxt    = LS_VAL;
                end
            end
            default: begin
                p.nxt = state_i;
            end
        endcase

        if (dirty_miss && (kind_i == AK_READ || kind_i == AK_WRITE)) begin
            p.ops[0] = MOP_WBACK;
            p.ops[1] = first_op;
        end else begin
            p.ops[0] = first_op;
            p.ops[1] = MOP_NONE;
        end
    end

    assign plan_o = p;

endmodule

// File: rtl/dcl_seq.sv
module dcl_seq
    import dcl_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 req_valid_i,
    input  plan_t                plan_i,
    input  logic                 mem_done_i,
    output line_state_e          state_o,
    output logic                 ready_o,
    output logic                 mem_req_o,
    output mem_op_e              mem_op_o,
    output logic                 cache_wr_o,
    output logic                 supply_o,
    output logic                 err_o
);

    typedef enum logic {SQ_IDLE, SQ_BUSY} seq_e;

    typedef struct packed {
        seq_e                     fsm;
        mem_op_e [OPQ_DEPTH-1:0]  ops;
        line_state_e              nxt;
        logic                     wr_cache;
        logic                     supply;
        line_state_e              state;
        logic                     err;
    } seq_regs_t;

    seq_regs_t r_q, r_d;
    logic      commit;

    assign commit = (r_q.fsm == SQ_BUSY) && (r_q.ops[0] == MOP_NONE);

    always_comb begin
        r_d     = r_q;
        r_d.err = 1'b0;
        case (r_q.fsm)
            SQ_IDLE: begin
                if (req_valid_i) begin
                    if (plan_i.err) begin
                        r_d.err = 1'b1;
                    end else begin
                        r_d.fsm      = SQ_BUSY;
                        r_d.ops      = plan_i.ops;
                        r_d.nxt      = plan_i.nxt;
                        r_d.wr_cache = plan_i.wr_cache;
                        r_d.supply   = plan_i.supply;
                    end
                end
            end
            default: begin
                if (r_q.ops[0] != MOP_NONE) begin
                    if (mem_done_i) begin
                        for (int i = 0; i < OPQ_DEPTH - 1; i++) begin
                            r_d.ops[i] = r_q.ops[i+1];
                        end
                        r_d.ops[OPQ_DEPTH-1] = MOP_NONE;
                    end
                end else begin
                    r_d.state = r_q.nxt;
                    r_d.fsm   = SQ_IDLE;
                end
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q       <= '0;
            r_q.fsm   <= SQ_IDLE;
            r_q.state <= LS_INV;
            r_q.nxt   <= LS_INV;
        end else begin
            r_q <= r_d;
        end
    end

    assign state_o    = r_q.state;
    assign ready_o    = (r_q.fsm == SQ_IDLE);
    assign mem_req_o  = (r_q.fsm == SQ_BUSY) && (r_q.ops[0] != MOP_NONE);
    assign mem_op_o   = mem_req_o ? r_q.ops[0] : MOP_NONE;
    assign cache_wr_o = commit && r_q.wr_cache;
    assign supply_o   = commit && r_q.supply;
    assign err_o      = r_q.err;

    AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_o && !mem_done_i) |=> (mem_req_o && $stable(mem_op_o))); // R12

    AST_STATE_AT_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_o |=> $stable(state_o)); // R12

    AST_STROBES_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_o || ready_o) |-> (!cache_wr_o && !supply_o)); // R12

    AST_ERR_ON_INVALID: assert property (@(posedge clk) disable iff (!rst_n)
        err_o |-> (state_o == LS_INV && ready_o)); // R9

    AST_ERR_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        err_o |=> (!err_o || $past(req_valid_i))); // R9

endmodule

// File: rtl/dcache_line_ctrl.sv
module dcache_line_ctrl
    import dcl_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 req_valid,
    input  logic [KIND_W-1:0]    req_kind,
    input  logic                 req_hit,
    input  logic                 req_copyback,
    output logic                 ready,
    output logic [STATE_W-1:0]   line_state,
    output logic                 mem_req,
    output logic [MOP_W-1:0]     mem_op,
    input  logic                 mem_done,
    output logic                 cache_wr,
    output logic                 cpu_supply,
    output logic                 err_hit_inv
);

    plan_t       plan;
    line_state_e cur_state;
    mem_op_e     cur_op;

    dcl_decode u_decode (
        .state_i    (cur_state),
        .kind_i     (req_kind),
        .hit_i      (req_hit),
        .copyback_i (req_copyback),
        .plan_o     (plan)
    );

    dcl_seq u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .req_valid_i (req_valid),
        .plan_i      (plan),
        .mem_done_i  (mem_done),
        .state_o     (cur_state),
        .ready_o     (ready),
        .mem_req_o   (mem_req),
        .mem_op_o    (cur_op),
        .cache_wr_o  (cache_wr),
        .supply_o    (cpu_supply),
        .err_o       (err_hit_inv)
    );

    assign line_state = cur_state;
    assign mem_op     = cur_op;

endmodule

// File: tb/test_dcache_line_ctrl.sv
module test_dcache_line_ctrl;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       req_valid = 1'b0;
    logic [2:0] req_kind = 3'd0;
    logic       req_hit = 1'b0;
    logic       req_copyback = 1'b0;
    logic       ready;
    logic [1:0] line_state;
    logic       mem_req;
    logic [1:0] mem_op;
    logic       mem_done = 1'b0;
    logic       cache_wr;
    logic       cpu_supply;
    logic       err_hit_inv;

    int checks = 0;
    int errors = 0;

    always #10ns clk = ~clk;

    dcache_line_ctrl i_dcache_line_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .req_valid    (req_valid),
        .req_kind     (req_kind),
        .req_hit      (req_hit),
        .req_copyback (req_copyback),
        .ready        (ready),
        .line_state   (line_state),
        .mem_req      (mem_req),
        .mem_op       (mem_op),
        .mem_done     (mem_done),
        .cache_wr     (cache_wr),
        .cpu_supply   (cpu_supply),
        .err_hit_inv  (err_hit_inv)
    );

    task automatic chk(input bit ok, input string tag, input string what, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    // Expected behaviour per requirement. Codes: state 0/1/2, op 1 fill, 2 word, 3 writeback.
    function automatic void model(input int st, input int kind, input int hit, input int cb,
                                  output int e_err, output int e_op0, output int e_op1,
                                  output int e_nxt, output int e_wr, output int e_sup);
        int op;
        e_err = 0; e_op0 = 0; e_op1 = 0; e_nxt = st; e_wr = 0; e_sup = 0; op = 0;
        if ((kind == 0 || kind == 1) && st == 0 && hit == 1) begin
            e_err = 1;                                        // R9
        end else if (kind == 0) begin
            e_sup = 1;
            if (hit == 0) begin op = 1; e_nxt = 1; end        // R2 R5 R11
        end else if (kind == 1) begin
            if (hit == 1) begin
                e_wr = 1;
                if (cb == 1) e_nxt = 2; else op = 2;          // R6 R11
            end else if (cb == 1) begin
                op = 1; e_wr = 1; e_nxt = 2;                  // R3 R7
            end else begin
                op = 2; e_nxt = (st == 0) ? 0 : 1;            // R4 R7
            end
        end else if (kind == 2) begin
            e_nxt = 0;                                        // R8
        end else if (kind == 3) begin
            if (st == 2) op = 3;                              // R10
            e_nxt = 0;
        end else if (kind == 4) begin
            if (st == 2) begin op = 3; e_nxt = 1; end         // R10
        end
        if (st == 2 && hit == 0 && (kind == 0 || kind == 1)) begin
            e_op0 = 3; e_op1 = op;                            // R11 writeback first
        end else begin
            e_op0 = op;
        end
    endfunction

    function automatic string tag_of(input int st, input int kind, input int hit, input int cb);
        if ((kind == 0 || kind == 1) && st == 0 && hit == 1) return "R9";
        if (kind == 2 || kind > 4) return "R8";
        if (kind >= 3) return "R10";
        if (st == 2) return "R11";
        if (st == 0 && kind == 0) return "R2";
        if (st == 0) return (cb == 1) ? "R3" : "R4";
        if (kind == 0) return "R5";
        return (hit == 1) ? "R6" : "R7";
    endfunction

    // Run one request and collect what the block does.
    task automatic run_req(input int kind, input int hit, input int cb,
                           output int g_err, output int g_op0, output int g_op1, output int g_nops,
                           output int g_wr, output int g_sup, output int g_nxt,
                           output int hold_bad, output int early_bad);
        int     st0;
        int     pending;
        int     held_op;
        st0 = int'(line_state);
        g_err = 0; g_op0 = 0; g_op1 = 0; g_nops = 0; g_wr = 0; g_sup = 0;
        hold_bad = 0; early_bad = 0; pending = 0; held_op = 0;
        @(negedge clk);
        req_valid = 1'b1; req_kind = 3'(kind); req_hit = 1'(hit); req_copyback = 1'(cb);
        @(negedge clk);
        req_valid = 1'b0;
        for (int cyc = 0; cyc < 40; cyc++) begin
            if (cyc > 0) @(negedge clk);
            mem_done = 1'b0;
            if (err_hit_inv) g_err++;
            if (cache_wr) g_wr++;
            if (cpu_supply) g_sup++;
            if (ready) break;
            if (mem_req) begin
                if (int'(line_state) != st0) early_bad++;
                if (pending == 0) begin
                    if (g_nops == 0) g_op0 = int'(mem_op); else g_op1 = int'(mem_op);
                    g_nops++;
                    held_op = int'(mem_op);
                    pending = 1;
                end else begin
                    if (int'(mem_op) != held_op) hold_bad++;
                    mem_done = 1'b1;
                    pending = 0;
                end
            end else if (pending == 1) begin
                hold_bad++;
                pending = 0;
            end
        end
        mem_done = 1'b0;
        g_nxt = int'(line_state);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic prep(input int st);
        int a, b, c, d, e, f, g, h, k;
        do_reset();
        if (st == 1) run_req(0, 0, 1, a, b, c, d, e, f, g, h, k);
        if (st == 2) run_req(1, 0, 1, a, b, c, d, e, f, g, h, k);
    endtask

    initial begin
        #(20ns * 150000);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int e_err, e_op0, e_op1, e_nxt, e_wr, e_sup, e_nops;
        int g_err, g_op0, g_op1, g_nops, g_wr, g_sup, g_nxt, hold_bad, early_bad;
        string t;

        do_reset();
        @(negedge clk);
        // R1 reset values
        chk(line_state == 2'd0, "R1", "line_state", int'(line_state), 0);
        chk(ready == 1'b1, "R1", "ready", int'(ready), 1);
        chk(!mem_req && !cache_wr && !cpu_supply && !err_hit_inv, "R1", "outputs idle",
            int'({mem_req, cache_wr, cpu_supply, err_hit_inv}), 0);

        for (int st = 0; st < 3; st++) begin
            for (int kind = 0; kind < 8; kind++) begin
                for (int hit = 0; hit < 2; hit++) begin
                    for (int cb = 0; cb < 2; cb++) begin
                        prep(st);
                        chk(int'(line_state) == st, "R12", "start state", int'(line_state), st);
                        model(st, kind, hit, cb, e_err, e_op0, e_op1, e_nxt, e_wr, e_sup);
                        e_nops = (e_op0 != 0 ? 1 : 0) + (e_op1 != 0 ? 1 : 0);
                        run_req(kind, hit, cb, g_err, g_op0, g_op1, g_nops, g_wr, g_sup, g_nxt,
                                hold_bad, early_bad);
                        t = tag_of(st, kind, hit, cb);
                        chk(g_err == e_err, t, $sformatf("err st%0d k%0d h%0d c%0d", st, kind, hit, cb), g_err, e_err);
                        chk(g_nops == e_nops, t, $sformatf("transfer count st%0d k%0d h%0d c%0d", st, kind, hit, cb), g_nops, e_nops);
                        chk(g_op0 == e_op0, t, $sformatf("first op st%0d k%0d h%0d c%0d", st, kind, hit, cb), g_op0, e_op0);
                        chk(g_op1 == e_op1, t, $sformatf("second op st%0d k%0d h%0d c%0d", st, kind, hit, cb), g_op1, e_op1);
                        chk(g_wr == e_wr, t, $sformatf("cache_wr st%0d k%0d h%0d c%0d", st, kind, hit, cb), g_wr, e_wr);
                        chk(g_sup == e_sup, t, $sformatf("cpu_supply st%0d k%0d h%0d c%0d", st, kind, hit, cb), g_sup, e_sup);
                        chk(g_nxt == e_nxt, t, $sformatf("end state st%0d k%0d h%0d c%0d", st, kind, hit, cb), g_nxt, e_nxt);
                        // R12 handshake hold and no early state change
                        chk(hold_bad == 0, "R12", "mem_req/mem_op held until done", hold_bad, 0);
                        chk(early_bad == 0, "R12", "state stable while transfers pending", early_bad, 0);
                    end
                end
            end
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule